// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped First-Level Cache

This block pairs a direct-mapped first-level cache with a small fully associative buffer. The buffer holds whole lines that the cache has recently pushed out. Each read request is looked up in the direct-mapped array and in every buffer entry at once.

A hit in the direct-mapped array answers in the same cycle the request is accepted. A hit in the buffer swaps two lines: the requested line moves into its direct-mapped slot, and that slot's previous occupant takes over the freed buffer entry. A miss in both issues a line request to the next memory level and waits for it. The returned line is written only into the direct-mapped array. The line it displaces, if that line was valid, goes into the buffer. The buffer replaces its least recently filled or swapped entry.

Requests use a valid/ready handshake. Ready stays low while a swap or a refill is in progress. Only reads are handled, so lines are never dirty.

Top module: `vc_cache_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0. Every line starts out absent, so the first access to any line is answered with source code 2 (memory).
- R2: A request that hits the direct-mapped array is answered in its acceptance cycle. The answer has `rsp_src` = 0 and `rsp_data` equal to the stored line.
- R3: A request that hits the victim buffer is answered exactly one cycle after acceptance. The answer has `rsp_src` = 1 and the buffered line, and `req_ready` is 0 in that cycle.
- R4: After a buffer hit, the requested line hits the direct-mapped array. The line that was displaced from that array slot hits in the buffer.
- R5: A request that misses both stores raises `mem_req_valid` in the cycle after acceptance. `mem_req_addr` equals the request address with the byte-select bits dropped. Both stay unchanged until `mem_resp_valid`. The answer (`rsp_src` = 2, data = `mem_resp_data`) comes in the same cycle as `mem_resp_valid`.
- R6: Refill data is written only into the direct-mapped array. The valid line it displaces enters the victim buffer and is afterwards found there.
- R7: An empty direct-mapped slot that is replaced puts nothing into the victim buffer. Buffer contents, including the least recent entry, survive such a refill.
- R8: When the buffer is full, a new eviction replaces the least recently used entry. A line that has just been written into an entry, by eviction or by swap, is the most recently used.
- R9: While a swap or a refill is in progress, `req_ready` is 0 and a presented request is not taken. Every accepted request gets exactly one answer.
- R10: The byte-select bits (the low log2(LINE_BYTES) address bits) do not affect the lookup. Addresses within one line hit the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request taken when both valid and ready are high |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | Answer present this cycle |
| rsp_src | output | 2 | Where the line came from: 0 L1, 1 victim buffer, 2 memory |
| rsp_data | output | 8*LINE_BYTES | Whole requested line |
| mem_req_valid | output | 1 | Line request to the next level outstanding |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address requested |
| mem_resp_valid | input | 1 | Line returned this cycle |
| mem_resp_data | input | 8*LINE_BYTES | Returned line |

## Verification
The bench builds the block with 12-bit addresses, 4-byte lines, only four direct-mapped slots and four buffer entries. With so few slots, conflicts arise after a handful of accesses, so the buffer fills, reaches full-buffer replacement and is exercised by repeated swaps within a short run. A three-cycle memory latency keeps the ready-low window open long enough to present a blocked request. The 10-bit line addresses let every returned line carry a pattern that names its own address.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Origin of the line returned with an answer.
  typedef enum logic [1:0] {
    SRC_L1  = 2'd0,
    SRC_VC  = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_MISS = 2'd2
  } st_e;

endpackage

// File: rtl/vc_l1_array.sv
module vc_l1_array #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag_out,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_tag_out = tag_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign rd_hit     = rd_valid && (rd_tag_out == rd_tag);

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int LADDR_W = 28,
  parameter int LINE_W  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] lk_line,
  output logic               hit,
  output logic [$clog2(ENTRIES)-1:0] hit_way,
  output logic [LINE_W-1:0]  hit_data,
  output logic [$clog2(ENTRIES)-1:0] alloc_way,
  input  logic               wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_way,
  input  logic               wr_valid,
  input  logic [LADDR_W-1:0] wr_line,
  input  logic [LINE_W-1:0]  wr_data
);
  localparam int WAY_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [LADDR_W-1:0] line_q [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];
  // Recency rank per entry: 0 is most recent, ENTRIES-1 is the replacement pick.
  logic [WAY_W-1:0]   rank_q [ENTRIES];
  logic [WAY_W-1:0]   rank_d [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic               free_found;

  // One comparator per entry, all working in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (line_q[g] == lk_line);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit_data = data_q[hit_way];

  // Free entry first, otherwise the least recently used one.
  always_comb begin
    alloc_way  = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid_q[i]) begin
        alloc_way  = WAY_W'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_q[i] == WAY_W'(ENTRIES - 1)) alloc_way = WAY_W'(i);
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) rank_d[i] = rank_q[i];
    if (wr_en) begin
      valid_d[wr_way] = wr_valid;
      for (int i = 0; i < ENTRIES; i++) begin
        if (WAY_W'(i) == wr_way)            rank_d[i] = '0;
        else if (rank_q[i] < rank_q[wr_way]) rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= WAY_W'(i);
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= rank_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[wr_way] <= wr_line;
      data_q[wr_way] <= wr_data;
    end
  end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic l1_hit,
  input  logic vc_hit,
  input  logic mem_resp_valid,
  output logic req_ready,
  output logic capture,
  output logic rsp_valid,
  output src_e rsp_src,
  output logic do_swap,
  output logic do_fill,
  output logic mem_req_valid
);
  st_e  state_q, state_d;
  logic run_q;

  always_comb begin
    state_d       = state_q;
    req_ready     = 1'b0;
    capture       = 1'b0;
    rsp_valid     = 1'b0;
    rsp_src       = SRC_L1;
    do_swap       = 1'b0;
    do_fill       = 1'b0;
    mem_req_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = run_q;
        if (req_valid && run_q) begin
          if (l1_hit) begin
            rsp_valid = 1'b1;
          end else if (vc_hit) begin
            capture = 1'b1;
            state_d = ST_SWAP;
          end else begin
            capture = 1'b1;
            state_d = ST_MISS;
          end
        end
      end
      ST_SWAP: begin
        rsp_valid = 1'b1;
        rsp_src   = SRC_VC;
        do_swap   = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_MISS: begin
        mem_req_valid = 1'b1;
        if (mem_resp_valid) begin
          rsp_valid = 1'b1;
          rsp_src   = SRC_MEM;
          do_fill   = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
    end
  end

endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int L1_LINES   = 64,
  parameter int VC_ENTRIES = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ADDR_W-1:0]                    req_addr,
  output logic                                 rsp_valid,
  output logic [1:0]                           rsp_src,
  output logic [8*LINE_BYTES-1:0]              rsp_data,
  output logic                                 mem_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_req_addr,
  input  logic                                 mem_resp_valid,
  input  logic [8*LINE_BYTES-1:0]              mem_resp_data
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(L1_LINES);
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;
  localparam int LINE_W  = 8 * LINE_BYTES;
  localparam int WAY_W   = $clog2(VC_ENTRIES);

  // Reset: asserted at once, released two clocks after rst_n rises.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic               capture, do_swap, do_fill;
  src_e               src;
  logic [LADDR_W-1:0] addr_q;
  logic [LADDR_W-1:0] lk_line;
  logic               unused_offset;

  logic               l1_hit, l1_valid;
  logic [TAG_W-1:0]   l1_tag;
  logic [LINE_W-1:0]  l1_data, l1_wr_data;

  logic               vc_hit, vc_wr_en;
  logic [WAY_W-1:0]   vc_hit_way, vc_alloc_way, vc_wr_way;
  logic [LINE_W-1:0]  vc_data;

  assign unused_offset = ^req_addr[OFF_W-1:0];

  // The request address is looked up while idle; the held copy afterwards.
  always_ff @(posedge clk) begin
    if (capture) addr_q <= req_addr[ADDR_W-1:OFF_W];
  end

  assign lk_line = req_ready ? req_addr[ADDR_W-1:OFF_W] : addr_q;

  vc_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .req_valid      (req_valid),
    .l1_hit         (l1_hit),
    .vc_hit         (vc_hit),
    .mem_resp_valid (mem_resp_valid),
    .req_ready      (req_ready),
    .capture        (capture),
    .rsp_valid      (rsp_valid),
    .rsp_src        (src),
    .do_swap        (do_swap),
    .do_fill        (do_fill),
    .mem_req_valid  (mem_req_valid)
  );

  assign l1_wr_data = do_swap ? vc_data : mem_resp_data;

  vc_l1_array #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
  ) u_l1 (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_idx     (lk_line[IDX_W-1:0]),
    .rd_tag     (lk_line[LADDR_W-1:IDX_W]),
    .rd_hit     (l1_hit),
    .rd_valid   (l1_valid),
    .rd_tag_out (l1_tag),
    .rd_data    (l1_data),
    .wr_en      (do_swap | do_fill),
    .wr_idx     (addr_q[IDX_W-1:0]),
    .wr_tag     (addr_q[LADDR_W-1:IDX_W]),
    .wr_data    (l1_wr_data)
  );

  // The old L1 occupant enters the buffer on a swap, or on a fill if it is valid.
  assign vc_wr_en  = do_swap | (do_fill & l1_valid);
  assign vc_wr_way = do_swap ? vc_hit_way : vc_alloc_way;

  vc_victim_buf #(
    .ENTRIES (VC_ENTRIES),
    .LADDR_W (LADDR_W),
    .LINE_W  (LINE_W)
  ) u_vbuf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_line   (lk_line),
    .hit       (vc_hit),
    .hit_way   (vc_hit_way),
    .hit_data  (vc_data),
    .alloc_way (vc_alloc_way),
    .wr_en     (vc_wr_en),
    .wr_way    (vc_wr_way),
    .wr_valid  (l1_valid),
    .wr_line   ({l1_tag, addr_q[IDX_W-1:0]}),
    .wr_data   (l1_data)
  );

  always_comb begin
    case (src)
      SRC_VC:  rsp_data = vc_data;
      SRC_MEM: rsp_data = mem_resp_data;
      default: rsp_data = l1_data;
    endcase
  end

  assign rsp_src      = src;
  assign mem_req_addr = addr_q;

endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int LADDR_W = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [1:0]         rsp_src,
  input logic               mem_req_valid,
  input logic [LADDR_W-1:0] mem_req_addr,
  input logic               mem_resp_valid
);

  // R2
  l1_rsp_in_accept_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == 2'd0) |-> (req_valid && req_ready));

  // R3
  vc_rsp_one_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == 2'd1) |-> ($past(req_valid && req_ready) && !req_ready));

  // R5
  mem_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R5
  mem_rsp_with_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_src == 2'd2) |-> (mem_req_valid && mem_resp_valid));

  // R9
  no_accept_while_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R9
  busy_after_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_valid) |=> !req_ready);

  // R1
  src_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_src != 2'd3));

endmodule

bind vc_cache_top vc_cache_chk #(.LADDR_W(LADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_src        (rsp_src),
  .mem_req_valid  (mem_req_valid),
  .mem_req_addr   (mem_req_addr),
  .mem_resp_valid (mem_resp_valid)
);

// File: tb/vc_cache_top_bench.sv
module vc_cache_top_bench;
  localparam int ADDR_W     = 12;
  localparam int LINE_BYTES = 4;
  localparam int L1_LINES   = 4;
  localparam int VC_ENTRIES = 4;
  localparam int LADDR_W    = 10;
  localparam int LINE_W     = 32;
  localparam int MEM_LAT    = 3;

  logic              clk, rst_n;
  logic              req_valid, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic [1:0]        rsp_src;
  logic [LINE_W-1:0] rsp_data;
  logic              mem_req_valid;
  logic [LADDR_W-1:0] mem_req_addr;
  logic              mem_resp_valid;
  logic [LINE_W-1:0] mem_resp_data;

  vc_cache_top #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .L1_LINES(L1_LINES), .VC_ENTRIES(VC_ENTRIES)
  ) u_vc_cache_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [LINE_W-1:0] pat(input logic [LADDR_W-1:0] la);
    return {6'h2B, la, 6'h15, la};
  endfunction

  // Reference model: direct-mapped slots plus a recency-ordered list (front = newest).
  logic               m_v    [L1_LINES];
  logic [LADDR_W-1:0] m_line [L1_LINES];
  logic [LADDR_W-1:0] m_vc   [$];

  function automatic int model_access(input logic [LADDR_W-1:0] la);
    int idx = int'(la[1:0]);
    int pos = -1;
    if (m_v[idx] && m_line[idx] == la) return 0;
    foreach (m_vc[k]) if (m_vc[k] == la) pos = k;
    if (pos >= 0) begin
      m_vc.delete(pos);
      m_vc.push_front(m_line[idx]);
      m_line[idx] = la;
      return 1;
    end
    if (m_v[idx]) begin
      if (m_vc.size() == VC_ENTRIES) void'(m_vc.pop_back());
      m_vc.push_front(m_line[idx]);
    end
    m_v[idx]    = 1'b1;
    m_line[idx] = la;
    return 2;
  endfunction

  // Scoreboard queues
  int                 exp_src_q  [$];
  logic [LINE_W-1:0]  exp_data_q [$];
  string              exp_tag_q  [$];
  int                 acc_q      [$];
  logic [LADDR_W-1:0] mem_exp_q  [$];
  int                 last_resp_cyc = -1;

  // Driver: computes the expected answer and presents one request.
  task automatic access(input logic [ADDR_W-1:0] a, input string tag);
    logic [LADDR_W-1:0] la;
    int  s;
    bit  ok;
    la = a[ADDR_W-1:2];
    s  = model_access(la);
    @(negedge clk);
    exp_src_q.push_back(s);
    exp_data_q.push_back(pat(la));
    exp_tag_q.push_back(tag);
    if (s == 2) mem_exp_q.push_back(la);
    req_valid = 1'b1;
    req_addr  = a;
    do begin
      #3;
      ok = req_ready;
      if (!ok) @(negedge clk);
    end while (!ok);
    acc_q.push_back(cyc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops expectations as answers appear.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && rsp_valid) begin
        int s; logic [LINE_W-1:0] d; string t; int a; int ecyc;
        if (exp_src_q.size() == 0 || acc_q.size() == 0) begin
          chk(1'b0, "R9", "answer without accepted request", 1, 0);
        end else begin
          s = exp_src_q.pop_front();
          d = exp_data_q.pop_front();
          t = exp_tag_q.pop_front();
          a = acc_q.pop_front();
          ecyc = (s == 0) ? a : (s == 1) ? a + 1 : last_resp_cyc;
          chk(rsp_src == 2'(s), t, "source", rsp_src, s);
          chk(rsp_data == d, t, "data", rsp_data, d);
          chk(cyc == ecyc, t, "answer cycle", cyc, ecyc);
        end
      end
    end
  end

  // Next-level memory model with fixed latency.
  initial begin
    int cnt;
    logic [LADDR_W-1:0] la;
    cnt = 0;
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_resp_valid) begin
        mem_resp_valid = 1'b0;
        cnt = 0;
      end else if (rst_n && mem_req_valid) begin
        if (cnt == 0) chk(!req_ready, "R9", "ready while refill outstanding", req_ready, 0);
        cnt++;
        if (cnt == MEM_LAT) begin
          la = (mem_exp_q.size() != 0) ? mem_exp_q.pop_front() : '1;
          chk(mem_req_addr == la, "R5", "line address", mem_req_addr, la);
          mem_resp_data  = pat(mem_req_addr);
          mem_resp_valid = 1'b1;
          last_resp_cyc  = cyc;
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < L1_LINES; i++) m_v[i] = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #4;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "no answer after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "no memory request after reset", mem_req_valid, 0);

    access(12'h000, "R1");   // cold miss, empty slot
    access(12'h001, "R10");  // same line, other byte
    access(12'h002, "R2");
    access(12'h010, "R6");   // conflict: old line goes to buffer
    access(12'h003, "R3");   // buffer hit, swap
    access(12'h000, "R4");   // now in L1
    access(12'h010, "R4");   // displaced line in buffer
    access(12'h020, "R6");
    access(12'h030, "R6");
    access(12'h040, "R6");   // buffer now full
    access(12'h050, "R8");   // replaces least recent
    access(12'h020, "R8");   // swap makes entry newest
    access(12'h000, "R8");
    access(12'h010, "R8");
    access(12'h050, "R8");
    // Empty slots: refills must not disturb the buffer.
    access(12'h004, "R7");
    access(12'h008, "R7");
    access(12'h00C, "R7");
    access({m_vc[m_vc.size()-1], 2'b00}, "R7");

    lfsr = 16'hACE1;
    repeat (80) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access({5'd0, lfsr[6:4], lfsr[3:2], lfsr[1:0]}, "R8");
    end

    repeat (20) @(negedge clk);
    chk(exp_src_q.size() == 0, "R9", "every accepted request answered", exp_src_q.size(), 0);
    chk(mem_exp_q.size() == 0, "R5", "every expected refill requested", mem_exp_q.size(), 0);
    report();
  end

endmodule